// File: doc/BRIEF.md
# Static Memory Access Sequencer

This block runs one access at a time against a boot ROM region, a peripheral I/O region or an asynchronous static RAM region of a memory controller. A request supplies an address, a read/write flag, a region code and a 32-bit write word. The block then steps through a fixed phase pattern for that region: a lead-in cycle, one or more data phases stretched by programmable wait states, and a lead-out cycle. While it does so, it drives chip select, output enable, write enable, address and write data toward the device.

Devices narrower than 32 bits are served by repeating the data phases. A read gathers bytes or half-words into a full word, with the first beat landing in the most significant position. A write sends the word out piece by piece, starting with its most significant part. The I/O and RAM regions may each let an external ready line hold the last data cycle of a beat. Writes to the ROM region are refused unless enabled. Timing and width fields come from two configuration words that are held at the inputs and sampled when a request is taken.

Top module: `smem_seq`

## Requirements
- R1: After reset, `reqReady` is high, `rspValid` is low, and `memCs`, `memOe` and `memWe` are all low.
- R2: Region code 00 is ROM. A ROM read with W = `cfgRom[3:0]` and B beats keeps a chip select high for 2 + B·(2+W) cycles: a lead-in with no enables, then per beat a first data cycle held W extra cycles and a second data cycle, then a lead-out. `rspValid` pulses in the cycle after the lead-out.
- R3: A ROM write uses W = `cfgRom[7:4]` and keeps a chip select high for 2 + B·(1+W) cycles. Writes are allowed only when `cfgRom[11]` is set. When it is clear, the write gets `rspErr` in the cycle after acceptance, with no chip select and no change to memory.
- R4: Width codes are 00 = 8 bit (B=4), 01 = 16 bit (B=2), and 10 or 11 = 32 bit (B=1); the ROM width is `cfgRom[9:8]`. Beat k uses address base + k (8 bit) or base + 2k (16 bit), where base is the request address with bits [1:0] cleared. Read data sits on `memDin[7:0]` or `memDin[15:0]`, and beat 0 becomes the most significant byte or half-word of `rspRdata`.
- R5: On a narrow write, beat k carries byte (or half-word) k of the write word, counted from the most significant end. That piece is copied across all lanes of `memDout`.
- R6: Region code 01 is I/O. Its reads and writes follow the same phase counts, with W = `cfgRom[23:20]` for both directions and width `cfgRom[28:27]`. `memOe` and `memWe` are never high together.
- R7: When `cfgRom[26]` is set, an I/O data cycle whose wait count is used up repeats while `memBrdy` is low. When the bit is clear, `memBrdy` has no effect on I/O timing.
- R8: Region code 10 is RAM: read W = `cfgRam[1:0]`, write W = `cfgRam[3:2]`, width `cfgRam[5:4]`. `cfgRam[7]` enables stretching by `memBrdy` exactly as in R7.
- R9: ROM accesses ignore `memBrdy`.
- R10: Wait counts, width and enables are taken when the request is accepted. Changing `cfgRom` or `cfgRam` during an access affects only later accesses.
- R11: Only one access is outstanding. `reqReady` is high only when idle, `rspValid` is a one-cycle pulse, and at most one chip select is high at a time.
- R12: Region code 11 is unmapped. It gets `rspErr` in the cycle after acceptance, with no chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle; request taken when both are high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqRegion | input | 2 | 00 ROM, 01 I/O, 10 RAM, 11 unmapped |
| reqAddr | input | ADDR_W | Byte address; bits [1:0] ignored |
| reqWdata | input | 32 | Write word |
| cfgRom | input | 32 | ROM and I/O timing, width and enable fields |
| cfgRam | input | 32 | RAM timing, width and ready-enable fields |
| rspValid | output | 1 | One-cycle response pulse |
| rspErr | output | 1 | Error response, valid with rspValid |
| rspRdata | output | 32 | Read word, valid with rspValid |
| memCs | output | 3 | One-hot chip select: bit 0 ROM, bit 1 I/O, bit 2 RAM |
| memAddr | output | ADDR_W | Device byte address of the current beat |
| memOe | output | 1 | Read enable during read data cycles |
| memWe | output | 1 | Write enable during write data cycles |
| memDout | output | 32 | Write data toward the device |
| memDin | input | 32 | Read data from the device |
| memBrdy | input | 1 | Device ready for stretchable regions |

## Verification
The bench builds the block with the default `ADDR_W` of 16 and a byte-wide model of all three devices that follows the width configured for each access. With every width code in use and wait counts at 0, mid-range and the field maxima (15 for ROM and I/O, 3 for RAM), the latency formula is checked across one, two and four beats. The ready line is held low for chosen spans, both shorter and longer than the programmed wait count. That shows stretching only where it is enabled, and only after the wait count has run out. Written words are read back at a different width, which confirms the big-endian split and assembly.

// File: rtl/smem_seq_pkg.sv
package smem_seq_pkg;

  localparam int WS_W      = 4;
  localparam int BEAT_W    = 2;
  localparam int N_REGIONS = 3;

  // ROM / I/O configuration word field positions
  localparam int ROM_RWS_LO   = 0;
  localparam int ROM_WWS_LO   = 4;
  localparam int ROM_WIDTH_LO = 8;
  localparam int ROM_WEN_BIT  = 11;
  localparam int IO_WS_LO     = 20;
  localparam int IO_BRDY_BIT  = 26;
  localparam int IO_WIDTH_LO  = 27;

  // RAM configuration word field positions
  localparam int RAM_RWS_LO   = 0;
  localparam int RAM_WWS_LO   = 2;
  localparam int RAM_WIDTH_LO = 4;
  localparam int RAM_BRDY_BIT = 7;

  typedef enum logic [1:0] {
    RG_ROM  = 2'd0,
    RG_IO   = 2'd1,
    RG_RAM  = 2'd2,
    RG_NONE = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    W8  = 2'd0,
    W16 = 2'd1,
    W32 = 2'd2
  } width_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic              load;
    logic              cs;
    logic              oe;
    logic              we;
    logic              capture;
    logic [BEAT_W-1:0] beat;
    width_e            width;
    region_e           region;
  } seq_strobe_t;

  function automatic width_e normWidth(input logic [1:0] code);
    case (code)
      2'b00:   return W8;
      2'b01:   return W16;
      default: return W32;
    endcase
  endfunction

  function automatic logic [BEAT_W-1:0] lastBeatOf(input width_e w);
    case (w)
      W8:      return 2'd3;
      W16:     return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/smem_seq_ctrl.sv
module smem_seq_ctrl
  import smem_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [1:0]  reqRegion,
  input  logic [31:0] cfgRom,
  input  logic [31:0] cfgRam,
  input  logic        memBrdy,
  output logic        reqReady,
  output logic        rspValid,
  output logic        rspErr,
  output seq_strobe_t strobe
);

  typedef enum logic [2:0] {
    S_IDLE, S_LEAD, S_DATA1, S_DATA2, S_TAIL, S_RESP
  } state_e;

  state_e            state;
  logic [WS_W-1:0]   wsInit, wsCnt;
  logic [BEAT_W-1:0] beat, lastBeat;
  logic              isWrite, brdyEn, errFlag;
  width_e            width;
  region_e           region;

  // decode of the request at acceptance time
  logic [WS_W-1:0] dWs;
  width_e          dWidth;
  logic            dBrdy, dErr;

  always_comb begin
    dWs    = '0;
    dWidth = W32;
    dBrdy  = 1'b0;
    dErr   = 1'b0;
    case (region_e'(reqRegion))
      RG_ROM: begin
        dWs    = reqWrite ? cfgRom[ROM_WWS_LO +: WS_W] : cfgRom[ROM_RWS_LO +: WS_W];
        dWidth = normWidth(cfgRom[ROM_WIDTH_LO +: 2]);
        dErr   = reqWrite && !cfgRom[ROM_WEN_BIT];
      end
      RG_IO: begin
        dWs    = cfgRom[IO_WS_LO +: WS_W];
        dWidth = normWidth(cfgRom[IO_WIDTH_LO +: 2]);
        dBrdy  = cfgRom[IO_BRDY_BIT];
      end
      RG_RAM: begin
        dWs    = reqWrite ? WS_W'(cfgRam[RAM_WWS_LO +: 2]) : WS_W'(cfgRam[RAM_RWS_LO +: 2]);
        dWidth = normWidth(cfgRam[RAM_WIDTH_LO +: 2]);
        dBrdy  = cfgRam[RAM_BRDY_BIT];
      end
      default: dErr = 1'b1;
    endcase
  end

  logic accept, holdBeat, beatDone;
  assign accept   = reqValid && (state == S_IDLE);
  assign holdBeat = brdyEn && !memBrdy;
  assign beatDone = (beat == lastBeat);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      wsInit   <= '0;
      wsCnt    <= '0;
      beat     <= '0;
      lastBeat <= '0;
      isWrite  <= 1'b0;
      brdyEn   <= 1'b0;
      errFlag  <= 1'b0;
      width    <= W32;
      region   <= RG_NONE;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          isWrite  <= reqWrite;
          region   <= region_e'(reqRegion);
          width    <= dWidth;
          wsInit   <= dWs;
          brdyEn   <= dBrdy;
          errFlag  <= dErr;
          beat     <= '0;
          lastBeat <= lastBeatOf(dWidth);
          state    <= dErr ? S_RESP : S_LEAD;
        end
        S_LEAD: begin
          wsCnt <= wsInit;
          state <= S_DATA1;
        end
        S_DATA1: begin
          if (wsCnt != '0) begin
            wsCnt <= wsCnt - WS_W'(1);
          end else if (!holdBeat) begin
            if (!isWrite) begin
              state <= S_DATA2;
            end else if (beatDone) begin
              state <= S_TAIL;
            end else begin
              beat  <= beat + BEAT_W'(1);
              wsCnt <= wsInit;
            end
          end
        end
        S_DATA2: begin
          if (beatDone) begin
            state <= S_TAIL;
          end else begin
            beat  <= beat + BEAT_W'(1);
            wsCnt <= wsInit;
            state <= S_DATA1;
          end
        end
        S_TAIL:  state <= S_RESP;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load    = accept;
    strobe.cs      = (state == S_LEAD) || (state == S_DATA1) || (state == S_DATA2) || (state == S_TAIL);
    strobe.oe      = !isWrite && ((state == S_DATA1) || (state == S_DATA2));
    strobe.we      = isWrite && (state == S_DATA1);
    strobe.capture = (state == S_DATA2);
    strobe.beat    = beat;
    strobe.width   = width;
    strobe.region  = region;
  end

  assign reqReady = (state == S_IDLE);
  assign rspValid = (state == S_RESP);
  assign rspErr   = (state == S_RESP) && errFlag;

endmodule

// File: rtl/smem_seq_dp.sv
module smem_seq_dp
  import smem_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seq_strobe_t          strobe,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [31:0]          reqWdata,
  input  logic [31:0]          memDin,
  output logic [N_REGIONS-1:0] memCs,
  output logic [ADDR_W-1:0]    memAddr,
  output logic                 memOe,
  output logic                 memWe,
  output logic [31:0]          memDout,
  output logic [31:0]          rspRdata
);

  logic [ADDR_W-1:0] addrBase;
  logic [31:0]       wdataReg, rdataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrBase <= '0;
      wdataReg <= '0;
      rdataReg <= '0;
    end else begin
      if (strobe.load) begin
        addrBase <= {reqAddr[ADDR_W-1:2], 2'b00};
        wdataReg <= reqWdata;
        rdataReg <= '0;
      end
      if (strobe.capture) begin
        case (strobe.width)
          W8:      rdataReg[{~strobe.beat, 3'b000} +: 8]     <= memDin[7:0];
          W16:     rdataReg[{~strobe.beat[0], 4'b0000} +: 16] <= memDin[15:0];
          default: rdataReg <= memDin;
        endcase
      end
    end
  end

  logic [ADDR_W-1:0] beatOffset;
  always_comb begin
    case (strobe.width)
      W8: begin
        beatOffset = ADDR_W'(strobe.beat);
        memDout    = {4{wdataReg[{~strobe.beat, 3'b000} +: 8]}};
      end
      W16: begin
        beatOffset = ADDR_W'({strobe.beat[0], 1'b0});
        memDout    = {2{wdataReg[{~strobe.beat[0], 4'b0000} +: 16]}};
      end
      default: begin
        beatOffset = '0;
        memDout    = wdataReg;
      end
    endcase
  end

  assign memAddr  = addrBase + beatOffset;
  assign memOe    = strobe.oe;
  assign memWe    = strobe.we;
  assign rspRdata = rdataReg;

  for (genvar g = 0; g < N_REGIONS; g++) begin : g_cs
    assign memCs[g] = strobe.cs && (strobe.region == region_e'(g));
  end

endmodule

// File: rtl/smem_seq.sv
module smem_seq
  import smem_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [1:0]        reqRegion,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic [31:0]       cfgRom,
  input  logic [31:0]       cfgRam,
  output logic              rspValid,
  output logic              rspErr,
  output logic [31:0]       rspRdata,
  output logic [2:0]        memCs,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memOe,
  output logic              memWe,
  output logic [31:0]       memDout,
  input  logic [31:0]       memDin,
  input  logic              memBrdy
);

  seq_strobe_t strobe;

  smem_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqRegion(reqRegion),
    .cfgRom   (cfgRom),
    .cfgRam   (cfgRam),
    .memBrdy  (memBrdy),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .rspErr   (rspErr),
    .strobe   (strobe)
  );

  smem_seq_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .memDin  (memDin),
    .memCs   (memCs),
    .memAddr (memAddr),
    .memOe   (memOe),
    .memWe   (memWe),
    .memDout (memDout),
    .rspRdata(rspRdata)
  );

endmodule

// File: rtl/smem_seq_chk.sv
module smem_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWrite,
  input logic [1:0]        reqRegion,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [31:0]       reqWdata,
  input logic [31:0]       cfgRom,
  input logic [31:0]       cfgRam,
  input logic              rspValid,
  input logic              rspErr,
  input logic [31:0]       rspRdata,
  input logic [2:0]        memCs,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memOe,
  input logic              memWe,
  input logic [31:0]       memDout,
  input logic [31:0]       memDin,
  input logic              memBrdy
);

  logic taken, romLocked;
  assign taken     = reqValid && reqReady;
  assign romLocked = (reqRegion == 2'b00) && reqWrite && !cfgRom[11];

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCs == 3'b000 && !memOe && !memWe));

  p_cs_onehot_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(memCs));

  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  p_rom_lock_r3: assert property (@(posedge clk) disable iff (!rstN)
    (taken && romLocked) |=> (rspValid && rspErr && memCs == 3'b000));

  p_unmapped_r12: assert property (@(posedge clk) disable iff (!rstN)
    (taken && reqRegion == 2'b11) |=> (rspValid && rspErr && memCs == 3'b000));

  p_lead_in_r2: assert property (@(posedge clk) disable iff (!rstN)
    (taken && reqRegion != 2'b11 && !romLocked) |=>
      (memCs != 3'b000 && !memOe && !memWe && !rspValid));

  p_oe_we_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(memOe && memWe));

  p_enable_in_cs_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memOe || memWe) |-> (memCs != 3'b000));

  p_rsp_after_tail_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspErr) |-> ($past(memCs) != 3'b000 && !$past(memOe) && !$past(memWe)));

endmodule

bind smem_seq smem_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/smem_seq_test.sv
module smem_seq_test;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic          reqWrite = 1'b0;
  logic [1:0]    reqRegion = 2'b00;
  logic [AW-1:0] reqAddr = '0;
  logic [31:0]   reqWdata = '0;
  logic [31:0]   cfgRom = '0;
  logic [31:0]   cfgRam = '0;
  logic          rspValid, rspErr;
  logic [31:0]   rspRdata;
  logic [2:0]    memCs;
  logic [AW-1:0] memAddr;
  logic          memOe, memWe;
  logic [31:0]   memDout;
  logic [31:0]   memDin;
  logic          memBrdy = 1'b1;

  always #5 clk = ~clk;

  smem_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqRegion(reqRegion), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .cfgRom(cfgRom), .cfgRam(cfgRam),
    .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata),
    .memCs(memCs), .memAddr(memAddr), .memOe(memOe), .memWe(memWe),
    .memDout(memDout), .memDin(memDin), .memBrdy(memBrdy)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int csCount = 0;
  int devWidth = 2;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // ---------------- device model: byte array per region, big-endian -----
  logic [7:0] m [0:2][0:63];
  int ri;
  logic [5:0] ix;

  always @* begin
    ri = memCs[2] ? 2 : (memCs[1] ? 1 : 0);
    ix = memAddr[5:0];
    case (devWidth)
      0:       memDin = {24'h0, m[ri][ix]};
      1:       memDin = {16'h0, m[ri][ix], m[ri][ix + 6'd1]};
      default: memDin = {m[ri][ix], m[ri][ix + 6'd1], m[ri][ix + 6'd2], m[ri][ix + 6'd3]};
    endcase
  end

  always @(negedge clk) begin
    if (rstN && memWe) begin
      case (devWidth)
        0: begin
          m[ri][ix] = memDout[7:0];
          chk(memDout == {4{memDout[7:0]}}, "R5 byte lanes replicated", memDout, {4{memDout[7:0]}});
        end
        1: begin
          m[ri][ix]        = memDout[15:8];
          m[ri][ix + 6'd1] = memDout[7:0];
          chk(memDout == {2{memDout[15:0]}}, "R5 half lanes replicated", memDout, {2{memDout[15:0]}});
        end
        default: begin
          m[ri][ix]        = memDout[31:24];
          m[ri][ix + 6'd1] = memDout[23:16];
          m[ri][ix + 6'd2] = memDout[15:8];
          m[ri][ix + 6'd3] = memDout[7:0];
        end
      endcase
    end
  end

  // ---------------- scoreboard --------------------------------------------
  typedef struct {
    logic [31:0] data;
    bit          err;
    bit          chkData;
    int          lat;
    int          csExp;
    int          t0;
    int          cs0;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];

  always @(negedge clk) begin
    if (rstN) begin
      if (|memCs) csCount++;
      if (rspValid) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R11 response without request", 32'd1, 32'd0);
        end else begin
          exp_t  e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(rspErr == e.err, {t, " error flag"}, 32'(rspErr), 32'(e.err));
          chk((cyc - e.t0) == e.lat, {t, " latency"}, 32'(cyc - e.t0), 32'(e.lat));
          chk((csCount - e.cs0) == e.csExp, {t, " select cycles"}, 32'(csCount - e.cs0), 32'(e.csExp));
          if (e.chkData) chk(rspRdata == e.data, {t, " read data"}, rspRdata, e.data);
        end
      end
    end
  end

  // ---------------- driver ------------------------------------------------
  function automatic int rdS(input int beats, input int ws);
    return 2 + beats * (2 + ws);
  endfunction

  function automatic int wrS(input int beats, input int ws);
    return 2 + beats * (1 + ws);
  endfunction

  function automatic logic [31:0] mkRom(input int rws, input int wws, input int pw, input bit wen,
                                        input int iows, input int iow, input bit iordy);
    logic [31:0] v;
    v = '0;
    v[3:0]   = 4'(rws);
    v[7:4]   = 4'(wws);
    v[9:8]   = 2'(pw);
    v[11]    = wen;
    v[23:20] = 4'(iows);
    v[26]    = iordy;
    v[28:27] = 2'(iow);
    return v;
  endfunction

  function automatic logic [31:0] mkRam(input int rws, input int wws, input int w, input bit rdy);
    logic [31:0] v;
    v = '0;
    v[1:0] = 2'(rws);
    v[3:2] = 2'(wws);
    v[5:4] = 2'(w);
    v[7]   = rdy;
    return v;
  endfunction

  task automatic issue(input int rg, input bit wr, input int addr, input logic [31:0] wd,
                       input int w, input int stro, input int hold, input int extra,
                       input bit expErr, input string tag);
    exp_t e;
    int a;
    a = addr & ~3;
    devWidth = w;
    e.err = expErr;
    e.chkData = !wr && !expErr;
    e.data = (rg < 3) ? {m[rg][a], m[rg][a+1], m[rg][a+2], m[rg][a+3]} : 32'h0;
    e.lat = expErr ? 1 : stro + extra + 1;
    e.csExp = expErr ? 0 : stro + extra;
    e.t0 = cyc;
    e.cs0 = csCount;
    expQ.push_back(e);
    tagQ.push_back(tag);
    reqValid  = 1'b1;
    reqWrite  = wr;
    reqRegion = 2'(rg);
    reqAddr   = AW'(addr);
    reqWdata  = wd;
    if (hold > 0) memBrdy = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R11 busy after accept", 32'(reqReady), 32'd0);
    if (hold > 0) begin
      repeat (hold + 1) @(negedge clk);
      memBrdy = 1'b1;
    end
    while (!rspValid) @(negedge clk);
    @(negedge clk);
  endtask

  // ---------------- watchdog ----------------------------------------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", expQ.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- test sequence -----------------------------------------
  initial begin
    for (int r = 0; r < 3; r++)
      for (int i = 0; i < 64; i++)
        m[r][i] = 8'(r * 64 + i * 7 + 1);

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1 ready after reset", 32'(reqReady), 32'd1);
    chk(rspValid == 1'b0, "R1 no response after reset", 32'(rspValid), 32'd0);
    chk({memCs, memOe, memWe} == 5'b0, "R1 strobes idle", 32'({memCs, memOe, memWe}), 32'd0);

    // R2: ROM reads, 32 bit, wait counts 0 and 15 (write field differs)
    cfgRom = mkRom(0, 7, 2, 1'b0, 0, 2, 1'b0);
    issue(0, 1'b0, 8, '0, 2, rdS(1, 0), 0, 0, 1'b0, "R2 rom read ws0");
    cfgRom = mkRom(15, 3, 2, 1'b0, 0, 2, 1'b0);
    issue(0, 1'b0, 9, '0, 2, rdS(1, 15), 0, 0, 1'b0, "R2 rom read ws15");

    // R3: locked write refused, memory untouched; then enabled write
    cfgRom = mkRom(0, 2, 2, 1'b0, 0, 2, 1'b0);
    issue(0, 1'b1, 12, 32'hDEAD_BEEF, 2, 0, 0, 0, 1'b1, "R3 locked rom write");
    issue(0, 1'b0, 12, '0, 2, rdS(1, 0), 0, 0, 1'b0, "R3 rom unchanged after refusal");
    cfgRom = mkRom(0, 2, 2, 1'b1, 0, 2, 1'b0);
    issue(0, 1'b1, 12, 32'hA1B2_C3D4, 2, wrS(1, 2), 0, 0, 1'b0, "R3 rom write ws2");
    issue(0, 1'b0, 12, '0, 2, rdS(1, 0), 0, 0, 1'b0, "R3 rom readback");
    chk(rspRdata == 32'hA1B2_C3D4, "R3 written word", rspRdata, 32'hA1B2_C3D4);

    // R4: narrow ROM reads
    cfgRom = mkRom(1, 0, 1, 1'b1, 0, 2, 1'b0);
    issue(0, 1'b0, 16, '0, 1, rdS(2, 1), 0, 0, 1'b0, "R4 rom 16-bit read");
    cfgRom = mkRom(0, 0, 0, 1'b1, 0, 2, 1'b0);
    issue(0, 1'b0, 22, '0, 0, rdS(4, 0), 0, 0, 1'b0, "R4 rom 8-bit read");

    // R5: 8-bit write split, read back as 32 bit
    cfgRom = mkRom(0, 1, 0, 1'b1, 0, 2, 1'b0);
    issue(0, 1'b1, 24, 32'h1122_3344, 0, wrS(4, 1), 0, 0, 1'b0, "R5 rom 8-bit write");
    cfgRom = mkRom(0, 0, 3, 1'b1, 0, 2, 1'b0);
    issue(0, 1'b0, 24, '0, 2, rdS(1, 0), 0, 0, 1'b0, "R5 readback width 11");
    chk(rspRdata == 32'h1122_3344, "R5 byte order", rspRdata, 32'h1122_3344);

    // R6: I/O region
    cfgRom = mkRom(0, 0, 2, 1'b0, 3, 2, 1'b0);
    issue(1, 1'b0, 4, '0, 2, rdS(1, 3), 0, 0, 1'b0, "R6 io read ws3");
    cfgRom = mkRom(0, 0, 2, 1'b0, 0, 1, 1'b0);
    issue(1, 1'b1, 8, 32'hCAFE_F00D, 1, wrS(2, 0), 0, 0, 1'b0, "R6 io 16-bit write");
    issue(1, 1'b0, 8, '0, 1, rdS(2, 0), 0, 0, 1'b0, "R6 io 16-bit readback");
    chk(rspRdata == 32'hCAFE_F00D, "R6 io half-word order", rspRdata, 32'hCAFE_F00D);
    cfgRom = mkRom(0, 0, 2, 1'b0, 15, 2, 1'b0);
    issue(1, 1'b0, 40, '0, 2, rdS(1, 15), 0, 0, 1'b0, "R6 io read ws15");

    // R7: ready stretching on I/O
    cfgRom = mkRom(0, 0, 2, 1'b0, 0, 2, 1'b1);
    issue(1, 1'b0, 12, '0, 2, rdS(1, 0), 4, 4, 1'b0, "R7 io read stretched");
    cfgRom = mkRom(0, 0, 2, 1'b0, 2, 2, 1'b1);
    issue(1, 1'b1, 16, 32'h0BAD_F00D, 2, wrS(1, 2), 5, 3, 1'b0, "R7 io write stretched past waits");
    cfgRom = mkRom(0, 0, 2, 1'b0, 0, 2, 1'b0);
    issue(1, 1'b0, 20, '0, 2, rdS(1, 0), 3, 0, 1'b0, "R7 io ready ignored when disabled");

    // R9: ROM ignores ready
    cfgRom = mkRom(0, 0, 2, 1'b0, 0, 2, 1'b1);
    issue(0, 1'b0, 28, '0, 2, rdS(1, 0), 2, 0, 1'b0, "R9 rom ignores ready");

    // R8: RAM region
    cfgRam = mkRam(3, 0, 3, 1'b0);
    issue(2, 1'b0, 32, '0, 2, rdS(1, 3), 0, 0, 1'b0, "R8 ram read ws3");
    cfgRam = mkRam(0, 1, 1, 1'b0);
    issue(2, 1'b1, 36, 32'h5566_7788, 1, wrS(2, 1), 0, 0, 1'b0, "R8 ram 16-bit write ws1");
    cfgRam = mkRam(2, 0, 0, 1'b0);
    issue(2, 1'b0, 36, '0, 0, rdS(4, 2), 0, 0, 1'b0, "R8 ram 8-bit readback");
    chk(rspRdata == 32'h5566_7788, "R8 ram word", rspRdata, 32'h5566_7788);
    cfgRam = mkRam(1, 0, 2, 1'b1);
    issue(2, 1'b0, 44, '0, 2, rdS(1, 1), 3, 2, 1'b0, "R8 ram read stretched");

    // R10: configuration change during an access
    cfgRom = mkRom(2, 0, 2, 1'b0, 0, 2, 1'b0);
    fork
      begin
        @(negedge clk);
        cfgRom = mkRom(9, 0, 0, 1'b0, 0, 2, 1'b0);
      end
    join_none
    issue(0, 1'b0, 48, '0, 2, rdS(1, 2), 0, 0, 1'b0, "R10 old config kept");
    issue(0, 1'b0, 48, '0, 0, rdS(4, 9), 0, 0, 1'b0, "R10 new config on next access");

    // R12: unmapped region
    issue(3, 1'b0, 0, '0, 2, 0, 0, 0, 1'b1, "R12 unmapped read");
    issue(3, 1'b1, 0, 32'h1, 2, 0, 0, 0, 1'b1, "R12 unmapped write");

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R11 all responses seen", 32'(expQ.size()), 32'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule